// File: doc/BRIEF.md
# Glitch-Free Processor Clock Switcher

This block drives a processor clock from one of two free-running clock inputs. The two inputs may come from separate oscillators, with no phase or frequency relationship between them. The processor selects the clock by writing one data bit through an active-low write strobe. The bit is captured on the trailing, rising edge of the strobe. A value of 0 selects clock A and a value of 1 selects clock B.

Every write goes through the same steps, whether or not the selection changes. While the strobe is low, the next falling edge of the clock in use clears a two-stage gating chain, which holds the output low. When the strobe rises, the multiplexer moves to the requested clock. Falling edges of that clock then shift a high level through the chain. Only when the last stage is high is the multiplexed clock passed to the output again. The gating enable changes only while the multiplexed clock is low. As a result, no output phase can be shorter than the matching phase of an input clock.

Top module: `clk_glitchfree_switch`

## Requirements
- R1: While `rst` is high, `cpu_clk` is held low. After reset the block drives clock A, and its first rising edge comes within three clock-A periods of reset release.
- R2: The selection is the value of `sel_bit` at the rising edge of `wr_strobe_n` (0 selects clock A, 1 selects clock B). The value on `sel_bit` earlier in the strobe has no effect.
- R3: While `wr_strobe_n` is low, the first falling edge of the clock in use parks `cpu_clk` low. At most one rising edge of `cpu_clk` occurs during a strobe that lasts longer than one period of the clock in use.
- R4: After `wr_strobe_n` rises, the first rising edge of `cpu_clk` comes no earlier than one low phase of the new clock and no later than three periods of the new clock.
- R5: Once released, every rising edge of `cpu_clk` coincides with a rising edge of the selected input, so consecutive rising edges are one period of that input apart.
- R6: No high or low phase of `cpu_clk` is shorter than the shorter half-period of the two inputs.
- R7: The gating enable changes only while the multiplexed clock is low.
- R8: The last chain stage can go high only after the stage before it was already high at the previous falling edge of the multiplexed clock.
- R9: A write that repeats the current selection still parks and releases the output, with the gap bounds of R4 on the same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Free-running clock source A |
| clk_b | input | 1 | Free-running clock source B, unrelated to A |
| rst | input | 1 | Active-high reset: selects A and clears the gating chain |
| wr_strobe_n | input | 1 | Active-low processor write strobe for this block |
| sel_bit | input | 1 | Processor data bit 0, captured on the strobe's rising edge |
| cpu_clk | output | 1 | Gated, switched processor clock |

## Verification
The hardest case to reach is a strobe release that lands while the old clock is high and the new clock is low. Then the multiplexer produces a falling edge of its own, and the gating chain sees an edge that neither oscillator made. The stimulus runs the two inputs at unrelated periods (10 ns and 7.4 ns) and shifts the start of each write by a different fraction of a period. Over the sequence, releases land in many phase pairings of the two clocks. Every output phase is timed, so a runt pulse in any of these pairings shows up as a width failure.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;

  // Selection encoding: value of the processor data bit written through the strobe
  typedef enum logic {
    CLK_SEL_A = 1'b0,
    CLK_SEL_B = 1'b1
  } clk_sel_e;

  // Shortest gating chain that still spans one full cycle of the new clock
  localparam int MIN_GATE_STAGES = 2;

endpackage

// File: rtl/clksw_sel_reg.sv
`timescale 1ns/1ps
// Selection register, clocked by the trailing edge of the write strobe.
module clksw_sel_reg
  import clksw_pkg::*;
#(
  parameter clk_sel_e RESET_SEL = CLK_SEL_A
) (
  input  logic     rst,
  input  logic     wr_strobe_n,
  input  logic     sel_bit,
  output clk_sel_e sel_q
);

  // The strobe's rising edge is the only event that moves the selection.
  // Reset is asynchronous: the strobe may be idle for any length of time.
  always_ff @(posedge wr_strobe_n or posedge rst) begin
    if (rst) begin
      sel_q <= RESET_SEL;
    end else begin
      sel_q <= clk_sel_e'(sel_bit);
    end
  end

endmodule

// File: rtl/clksw_mux.sv
`timescale 1ns/1ps
// Two-way clock multiplexer. The mux may glitch when the selection moves;
// the gating chain keeps the output parked across that instant.
module clksw_mux
  import clksw_pkg::*;
(
  input  logic     clk_a,
  input  logic     clk_b,
  input  clk_sel_e sel,
  output logic     mux_clk
);

  always_comb begin
    unique case (sel)
      CLK_SEL_B: mux_clk = clk_b;
      default:   mux_clk = clk_a;
    endcase
  end

endmodule

// File: rtl/clksw_gate_chain.sv
`timescale 1ns/1ps
// Gating enable chain, clocked on falling edges of the multiplexed clock.
// A low strobe clears every stage; a high strobe lets a one ripple through.
module clksw_gate_chain #(
  parameter int STAGES = clksw_pkg::MIN_GATE_STAGES
) (
  input  logic              rst,
  input  logic              mux_clk,
  input  logic              hold_n,
  output logic [STAGES-1:0] chain_q,
  output logic              gate_en
);

  localparam int LAST = STAGES - 1;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      logic q;
      if (gi == 0) begin : g_head
        // First stage takes the strobe level itself
        always_ff @(negedge mux_clk or posedge rst) begin
          if (rst) begin
            q <= 1'b0;
          end else begin
            q <= hold_n;
          end
        end
      end else begin : g_tail
        // Later stages follow the previous one, cleared while the strobe is low
        always_ff @(negedge mux_clk or posedge rst) begin
          if (rst) begin
            q <= 1'b0;
          end else if (!hold_n) begin
            q <= 1'b0;
          end else begin
            q <= chain_q[gi-1];
          end
        end
      end
      assign chain_q[gi] = q;
    end
  endgenerate

  assign gate_en = chain_q[LAST];

endmodule

// File: rtl/clk_glitchfree_switch.sv
`timescale 1ns/1ps
// Top level: selection register, clock mux, gating chain and output gate.
module clk_glitchfree_switch
  import clksw_pkg::*;
#(
  parameter int       SYNC_STAGES = MIN_GATE_STAGES,
  parameter clk_sel_e RESET_SEL   = CLK_SEL_A
) (
  input  logic clk_a,
  input  logic clk_b,
  input  logic rst,
  input  logic wr_strobe_n,
  input  logic sel_bit,
  output logic cpu_clk
);

  clk_sel_e               sel_q;
  logic                   mux_clk;
  logic [SYNC_STAGES-1:0] chain_q;
  logic                   gate_en;

  clksw_sel_reg #(
    .RESET_SEL(RESET_SEL)
  ) u_sel (
    .rst        (rst),
    .wr_strobe_n(wr_strobe_n),
    .sel_bit    (sel_bit),
    .sel_q      (sel_q)
  );

  clksw_mux u_mux (
    .clk_a  (clk_a),
    .clk_b  (clk_b),
    .sel    (sel_q),
    .mux_clk(mux_clk)
  );

  clksw_gate_chain #(
    .STAGES(SYNC_STAGES)
  ) u_chain (
    .rst    (rst),
    .mux_clk(mux_clk),
    .hold_n (wr_strobe_n),
    .chain_q(chain_q),
    .gate_en(gate_en)
  );

  // Enable only moves on falling mux edges, so this AND cannot slice a pulse
  assign cpu_clk = mux_clk & gate_en;

endmodule

// File: rtl/clk_glitchfree_switch_chk.sv
`timescale 1ns/1ps
// Assertion checker, bound to the switcher top.
module clk_glitchfree_switch_chk
  import clksw_pkg::*;
#(
  parameter int STAGES = MIN_GATE_STAGES
) (
  input logic              rst,
  input logic              clk_a,
  input logic              clk_b,
  input logic              wr_strobe_n,
  input logic              mux_clk,
  input logic              cpu_clk,
  input clk_sel_e          sel_q,
  input logic [STAGES-1:0] chain_q
);

  logic last_q;
  assign last_q = chain_q[STAGES-1];

  always @(rst or cpu_clk) begin
    if (rst && $time > 0) begin
      AST_RESET_QUIET: assert (!cpu_clk) else $error("output active in reset"); // R1
    end
  end

  always @(last_q) begin
    if (!rst && $time > 0) begin
      AST_GATE_MOVES_LOW: assert (!mux_clk) else $error("enable moved with mux high"); // R7
    end
  end

  always @(posedge cpu_clk) begin
    if (!rst) begin
      AST_RISE_FROM_SOURCE: assert ((sel_q == CLK_SEL_B) ? clk_b : clk_a) else $error("rise not from selected input"); // R5
    end
  end

  AST_STROBE_PARKS: assert property (@(negedge mux_clk) disable iff (rst)
    !wr_strobe_n |=> !last_q) else $error("strobe did not park output"); // R3

  AST_CHAIN_ORDER: assert property (@(negedge mux_clk) disable iff (rst)
    $rose(last_q) |-> $past(chain_q[STAGES-2])) else $error("last stage skipped order"); // R8

endmodule

bind clk_glitchfree_switch clk_glitchfree_switch_chk #(
  .STAGES(SYNC_STAGES)
) u_chk (
  .rst        (rst),
  .clk_a      (clk_a),
  .clk_b      (clk_b),
  .wr_strobe_n(wr_strobe_n),
  .mux_clk    (mux_clk),
  .cpu_clk    (cpu_clk),
  .sel_q      (sel_q),
  .chain_q    (chain_q)
);

// File: tb/clk_glitchfree_switch_bench.sv
`timescale 1ns/1ps
module clk_glitchfree_switch_bench;

  localparam real CLK_PERIOD  = 10.0;   // clock A
  localparam real CLK_B_PER   = 7.4;    // clock B, unrelated to A
  localparam real MIN_PHASE   = 3.7;    // shorter half-period of the two
  localparam real TOL         = 0.01;
  localparam real WATCHDOG_NS = 200000.0;

  typedef struct {
    logic sel;
    real  period;
    real  t_rel;
    bit   same;
    bit   is_reset;
  } exp_item_t;

  logic clk_a, clk_b, rst, wr_strobe_n, sel_bit;
  logic cpu_clk;

  clk_glitchfree_switch u_clk_glitchfree_switch (
    .clk_a      (clk_a),
    .clk_b      (clk_b),
    .rst        (rst),
    .wr_strobe_n(wr_strobe_n),
    .sel_bit    (sel_bit),
    .cpu_clk    (cpu_clk)
  );

  int n_checks = 0;
  int n_errors = 0;
  int pushed   = 0;
  int done     = 0;
  int strobe_rises = 0;
  int hi_bad = 0, lo_bad = 0, pulses = 0;
  real min_hi = 1.0e9, min_lo = 1.0e9;
  exp_item_t q[$];

  initial begin
    clk_a = 1'b0;
    forever #(CLK_PERIOD / 2.0) clk_a = ~clk_a;
  end

  initial begin
    clk_b = 1'b0;
    #1.1;
    forever #(CLK_B_PER / 2.0) clk_b = ~clk_b;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input real act, input real exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
    end
  endtask

  // Phase-width monitor over the whole run
  real t_rise = 0.0, t_fall = 0.0;
  bit  seen_rise = 0, seen_fall = 0;
  always @(cpu_clk) begin
    if (!rst && $realtime > 0) begin
      if (cpu_clk === 1'b1) begin
        if (seen_fall) begin
          if ($realtime - t_fall < min_lo) min_lo = $realtime - t_fall;
          if ($realtime - t_fall < MIN_PHASE - TOL) lo_bad++;
        end
        t_rise = $realtime; seen_rise = 1; pulses++;
      end else if (cpu_clk === 1'b0) begin
        if (seen_rise) begin
          if ($realtime - t_rise < min_hi) min_hi = $realtime - t_rise;
          if ($realtime - t_rise < MIN_PHASE - TOL) hi_bad++;
        end
        t_fall = $realtime; seen_fall = 1;
      end
    end
  end

  always @(posedge cpu_clk) begin
    if (!wr_strobe_n) strobe_rises++;
  end

  // Monitor: pop expected release and compare the resumed output
  initial begin
    forever begin
      exp_item_t it;
      real t1, t2, t3, gap;
      wait (q.size() > 0);
      it = q.pop_front();
      @(posedge cpu_clk); t1 = $realtime;
      @(posedge cpu_clk); t2 = $realtime;
      @(posedge cpu_clk); t3 = $realtime;
      gap = t1 - it.t_rel;
      if (it.is_reset) begin
        check(gap <= 3.0 * it.period + TOL, "R1", "first rise after reset", gap, 3.0 * it.period);
        check((t2 - t1 > it.period - TOL) && (t2 - t1 < it.period + TOL),
              "R1", "period after reset", t2 - t1, it.period);
      end else begin
        check(gap >= it.period / 2.0 - TOL && gap <= 3.0 * it.period + TOL,
              it.same ? "R9" : "R4", "release gap", gap, 3.0 * it.period);
        check((t2 - t1 > it.period - TOL) && (t2 - t1 < it.period + TOL),
              "R2", "period of captured selection", t2 - t1, it.period);
      end
      check((t3 - t2 > it.period - TOL) && (t3 - t2 < it.period + TOL),
            "R5", "steady period", t3 - t2, it.period);
      done++;
    end
  end

  logic cur_sel = 1'b0;

  // Driver: one processor write; sel_bit holds the opposite value until late in the strobe
  task automatic do_write(input logic v, input int idx);
    exp_item_t it;
    #(3.3 + 1.7 * idx);
    strobe_rises = 0;
    sel_bit     = ~v;
    wr_strobe_n = 1'b0;
    #27.9;
    sel_bit = v;
    #2.0;
    check(strobe_rises <= 1, (v == cur_sel) ? "R9" : "R3", "rises during strobe",
          real'(strobe_rises), 1.0);
    it.sel = v;
    it.period = v ? CLK_B_PER : CLK_PERIOD;
    it.t_rel = $realtime;
    it.same = (v == cur_sel);
    it.is_reset = 1'b0;
    wr_strobe_n = 1'b1;
    q.push_back(it);
    pushed++;
    cur_sel = v;
    wait (done == pushed);
  endtask

  initial begin
    logic [7:0] pattern;
    exp_item_t rit;
    pattern = 8'b0101_1001;  // bit i is the value of write i
    rst = 1'b1;
    wr_strobe_n = 1'b1;
    sel_bit = 1'b1;
    #21.3;
    check(cpu_clk === 1'b0, "R1", "output in reset", real'(cpu_clk), 0.0);
    #22.6;
    check(cpu_clk === 1'b0, "R1", "output in reset", real'(cpu_clk), 0.0);
    #16.3;
    rst = 1'b0;
    rit.sel = 1'b0; rit.period = CLK_PERIOD; rit.t_rel = $realtime;
    rit.same = 1'b0; rit.is_reset = 1'b1;
    q.push_back(rit);
    pushed++;
    wait (done == pushed);
    for (int i = 0; i < 8; i++) begin
      do_write(pattern[i], i);
    end
    #50.0;
    check(hi_bad == 0, "R6", "short high phase (min seen)", min_hi, MIN_PHASE);
    check(lo_bad == 0, "R6", "short low phase (min seen)", min_lo, MIN_PHASE);
    check(pulses > 30, "R5", "output pulse count", real'(pulses), 30.0);
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(WATCHDOG_NS);
    n_checks++;
    n_errors++;
    $display("FAIL R4 watchdog: actual %0.1f ns expected finish before it", WATCHDOG_NS);
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule